// File: doc/BRIEF.md
# RAID-6 Partial-Stripe Parity Updater

This block refreshes the two parity columns of a RAID-6 stripe when only a contiguous run of data devices, indices `start` through `stop`, has been rewritten. It is given the current P and Q for one column and, for each rewritten device, a change term (the XOR of that device's old and new contents). It returns the new P and Q. These are the same values a full regeneration over the modified stripe would give, but the unchanged devices are never read.

A job is a sequence of beats on one valid/ready input port. The first beat carries the old P, the second carries the old Q, and then one change beat follows for each rewritten device. The change beats run from device `stop` down to device `start`. Devices above `stop` add nothing. Each device below `start` costs one internal cycle that only doubles the Q accumulator. The accumulator is then folded into the old Q. Each beat is `GROUPS` independent 16-byte groups. The result is held on an output valid/ready port until it is taken. A new job's first beat may be accepted in the same cycle that the previous result is taken.

Top module: `pq_delta_updater`

## Requirements
- R1: While reset is applied and after it is released, `m_valid` and `err_o` are 0 and `s_ready` is 1.
- R2: A job takes beats in a fixed order: old P, then old Q, then exactly `stop-start+1` change beats for devices `stop` down to `start`. Configuration is sampled when the old P beat is accepted.
- R3: The new P equals the old P XOR every change beat of the job.
- R4: The new Q equals the old Q XOR the sum over z from `start` to `stop` of change_z multiplied by 2^z in GF(2^8). Each byte is reduced by the polynomial 0x11d, and every byte lane is independent.
- R5: Each multiply-by-2 step works on each byte separately: the byte shifts left by one, and if its top bit was 1 it is then XORed with 0x1d.
- R6: After the final change beat is accepted, `s_ready` stays 0 and `m_valid` rises on the `start`-th following clock edge. When `start` is 0, `m_valid` rises on the accepting edge itself.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_p` and `m_q` hold their values. One cycle with `m_ready` at 1 removes the result.
- R8: If the configuration sampled with the old P beat breaks 0 ≤ start ≤ stop ≤ ndev-3, that beat is consumed and `err_o` is 1 for exactly the following cycle. No result is produced and the block returns to idle.
- R9: While a result is pending, `s_ready` follows `m_ready`. A new job's old P beat can therefore be accepted on the same edge that takes the result.
- R10: The new P and Q equal the P and Q regenerated over all `ndev-2` data devices of the modified stripe. P is the XOR of all data devices. Q is the Horner sum from the highest data device down to device 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ndev | input | IDX_W | Total device count including P and Q |
| cfg_start | input | IDX_W | Lowest rewritten data device |
| cfg_stop | input | IDX_W | Highest rewritten data device |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | GROUPS*128 | Old P, old Q or change term |
| m_valid | output | 1 | New P and Q are available |
| m_ready | input | 1 | Consumer takes the result |
| m_p | output | GROUPS*128 | New P |
| m_q | output | GROUPS*128 | New Q |
| err_o | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
Two functions can land on the same clock edge: handing off a finished result and starting the next job. The bench leaves a result pending, then raises `m_ready` together with the next job's old P beat. It judges the overlap by checking that `m_valid` drops after that edge and that the second job still produces parity equal to a full regeneration. A rejected configuration can also arrive on the edge where a result is taken. Error jobs therefore start from the idle state, and the bench checks that the pulse never coincides with a valid result.

// File: rtl/pq_upd_pkg.sv
package pq_upd_pkg;

  localparam logic [7:0] GF_TAP      = 8'h1d;
  localparam int         GROUP_BYTES = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QOLD,
    ST_DATA,
    ST_SHIFT,
    ST_DONE
  } pq_state_e;

  typedef struct packed {
    logic ld_p;
    logic ld_qold;
    logic seed;
    logic fold;
    logic dbl;
  } pq_ctl_t;

  function automatic logic [7:0] gf_x2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? GF_TAP : 8'h00);
  endfunction

endpackage

// File: rtl/pq_gf_double.sv
module pq_gf_double #(
  parameter int BYTES = 16
) (
  input  logic [BYTES*8-1:0] a,
  output logic [BYTES*8-1:0] y
);
  import pq_upd_pkg::*;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign y[b*8 +: 8] = gf_x2(a[b*8 +: 8]);
  end

endmodule

// File: rtl/pq_lane_group.sv
module pq_lane_group #(
  parameter int BYTES = 16
) (
  input  logic                 clk,
  input  pq_upd_pkg::pq_ctl_t  ctl,
  input  logic [BYTES*8-1:0]   din,
  output logic [BYTES*8-1:0]   p_o,
  output logic [BYTES*8-1:0]   q_o
);
  import pq_upd_pkg::*;

  localparam int W = BYTES * 8;

  logic [W-1:0] p_q, p_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] qold_q;
  logic [W-1:0] acc_x2;
  logic         p_en, acc_en;

  pq_gf_double #(.BYTES(BYTES)) u_dbl (
    .a (acc_q),
    .y (acc_x2)
  );

  // next-state for the P and Q working registers
  always_comb begin
    p_en   = ctl.ld_p | ctl.seed | ctl.fold;
    acc_en = ctl.seed | ctl.fold | ctl.dbl;
    p_d    = ctl.ld_p ? din : (p_q ^ din);
    if (ctl.seed)
      acc_d = din;
    else if (ctl.fold)
      acc_d = acc_x2 ^ din;
    else
      acc_d = acc_x2;
  end

  always_ff @(posedge clk) begin
    if (p_en)        p_q    <= p_d;
    if (acc_en)      acc_q  <= acc_d;
    if (ctl.ld_qold) qold_q <= din;
  end

  assign p_o = p_q;
  assign q_o = acc_q ^ qold_q;

endmodule

// File: rtl/pq_seq_ctrl.sv
module pq_seq_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     cfg_ndev,
  input  logic [IDX_W-1:0]     cfg_start,
  input  logic [IDX_W-1:0]     cfg_stop,
  input  logic                 s_valid,
  output logic                 s_ready,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic                 err_o,
  output pq_upd_pkg::pq_ctl_t  ctl
);
  import pq_upd_pkg::*;

  pq_state_e        state, state_n;
  logic [IDX_W-1:0] cnt, cnt_n;
  logic [IDX_W-1:0] sh_cnt, sh_n;
  logic [IDX_W-1:0] start_l, start_n;
  logic [IDX_W-1:0] stop_l, stop_n;
  logic             first, first_n;
  logic             err_q, err_n;
  logic             take, cfg_ok;
  logic [IDX_W-1:0] span;
  logic [IDX_W:0]   stop_lim;

  assign stop_lim = {1'b0, cfg_stop} + (IDX_W+1)'(3);
  assign cfg_ok   = (cfg_start <= cfg_stop) && (stop_lim <= {1'b0, cfg_ndev});
  assign span     = stop_l - start_l + IDX_W'(1);

  always_comb begin
    case (state)
      ST_IDLE, ST_QOLD, ST_DATA: s_ready = 1'b1;
      ST_DONE:                   s_ready = m_ready;
      default:                   s_ready = 1'b0;
    endcase
  end

  assign take    = s_valid & s_ready;
  assign m_valid = (state == ST_DONE);
  assign err_o   = err_q;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sh_n    = sh_cnt;
    start_n = start_l;
    stop_n  = stop_l;
    first_n = first;
    err_n   = 1'b0;
    ctl     = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (state == ST_DONE && m_ready) state_n = ST_IDLE;
        if (take) begin
          if (cfg_ok) begin
            state_n  = ST_QOLD;
            ctl.ld_p = 1'b1;
            start_n  = cfg_start;
            stop_n   = cfg_stop;
          end else begin
            state_n = ST_IDLE;
            err_n   = 1'b1;
          end
        end
      end
      ST_QOLD: begin
        if (take) begin
          ctl.ld_qold = 1'b1;
          cnt_n       = span;
          first_n     = 1'b1;
          state_n     = ST_DATA;
        end
      end
      ST_DATA: begin
        if (take) begin
          ctl.seed = first;
          ctl.fold = ~first;
          first_n  = 1'b0;
          cnt_n    = cnt - IDX_W'(1);
          if (cnt == IDX_W'(1)) begin
            if (start_l == '0) begin
              state_n = ST_DONE;
            end else begin
              state_n = ST_SHIFT;
              sh_n    = start_l;
            end
          end
        end
      end
      ST_SHIFT: begin
        ctl.dbl = 1'b1;
        sh_n    = sh_cnt - IDX_W'(1);
        if (sh_cnt == IDX_W'(1)) state_n = ST_DONE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh_cnt  <= '0;
      start_l <= '0;
      stop_l  <= '0;
      first   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      sh_cnt  <= sh_n;
      start_l <= start_n;
      stop_l  <= stop_n;
      first   <= first_n;
      err_q   <= err_n;
    end
  end

  // R2: the change-beat counter never leaves the span latched with old P
  a_r2_span_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (cnt != '0 && cnt <= span));

  // R6: the last doubling cycle hands straight over to the result
  a_r6_shift_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && sh_cnt == IDX_W'(1)) |=> m_valid);

  // R8: a rejection pulse only ever appears with the block idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state == ST_IDLE && !m_valid));

  // R9: taking a result together with a new beat leaves no stale result
  a_r9_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && s_valid) |=> !m_valid);

endmodule

// File: rtl/pq_delta_updater.sv
module pq_delta_updater #(
  parameter int GROUPS = 1,
  parameter int IDX_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          cfg_ndev,
  input  logic [IDX_W-1:0]          cfg_start,
  input  logic [IDX_W-1:0]          cfg_stop,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [GROUPS*128-1:0]     s_data,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [GROUPS*128-1:0]     m_p,
  output logic [GROUPS*128-1:0]     m_q,
  output logic                      err_o
);
  import pq_upd_pkg::*;

  localparam int GW = GROUP_BYTES * 8;

  logic    rst_meta, rst_sync;
  pq_ctl_t ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pq_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cfg_ndev  (cfg_ndev),
    .cfg_start (cfg_start),
    .cfg_stop  (cfg_stop),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .err_o     (err_o),
    .ctl       (ctl)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pq_lane_group #(.BYTES(GROUP_BYTES)) u_grp (
      .clk (clk),
      .ctl (ctl),
      .din (s_data[g*GW +: GW]),
      .p_o (m_p[g*GW +: GW]),
      .q_o (m_q[g*GW +: GW])
    );
  end

  // R7: a pending result is frozen until it is taken
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_sync)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_p) && $stable(m_q)));

endmodule

// File: tb/tb_pq_delta_updater.sv
module tb_pq_delta_updater;

  localparam int GROUPS = 2;
  localparam int IDX_W  = 5;
  localparam int W      = GROUPS * 128;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [IDX_W-1:0] cfg_ndev, cfg_start, cfg_stop;
  logic             s_valid, s_ready, m_valid, m_ready, err_o;
  logic [W-1:0]     s_data, m_p, m_q;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] od [32];
  logic [W-1:0] nw [32];

  always #2 clk = ~clk;

  pq_delta_updater #(.GROUPS(GROUPS), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ndev(cfg_ndev), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_p(m_p), .m_q(m_q), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dbl_v(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int b = 0; b < W/8; b++) begin
      logic [7:0] x;
      x = v[b*8 +: 8];
      r[b*8 +: 8] = (x << 1) ^ ((x & 8'h80) != 0 ? 8'h1d : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_v();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  // full regeneration (R10): sel=0 old stripe, sel=1 new stripe
  function automatic logic [W-1:0] regen_p(input int nd, input bit sel);
    logic [W-1:0] p = '0;
    for (int z = 0; z <= nd-3; z++) p ^= sel ? nw[z] : od[z];
    return p;
  endfunction

  function automatic logic [W-1:0] regen_q(input int nd, input bit sel);
    logic [W-1:0] q = '0;
    for (int z = nd-3; z >= 0; z--) q = dbl_v(q) ^ (sel ? nw[z] : od[z]);
    return q;
  endfunction

  task automatic send(input logic [W-1:0] d);
    bit ok;
    s_valid = 1'b1;
    s_data  = d;
    forever begin
      #1 ok = s_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // pattern: 0 random, 1 top-bit heavy bytes (R5)
  task automatic do_job(input int nd, input int st, input int sp, input int hold,
                        input bit predrain, input bit leave, input int pattern);
    logic [W-1:0] op, oq, ep, eq, dsum;
    for (int z = 0; z < 32; z++) begin
      od[z] = (pattern == 1) ? {(W/8){8'h80}} ^ W'(z) : rnd_v();
      nw[z] = od[z];
    end
    for (int z = st; z <= sp; z++)
      nw[z] = (pattern == 1) ? {(W/8){8'hff}} : rnd_v();
    op = regen_p(nd, 1'b0);
    oq = regen_q(nd, 1'b0);
    ep = regen_p(nd, 1'b1);
    eq = regen_q(nd, 1'b1);
    dsum = op;
    for (int z = st; z <= sp; z++) dsum ^= od[z] ^ nw[z];
    cfg_ndev  = IDX_W'(nd);
    cfg_start = IDX_W'(st);
    cfg_stop  = IDX_W'(sp);
    if (predrain) m_ready = 1'b1;
    send(op);
    m_ready = 1'b0;
    if (predrain) chk(!m_valid && s_ready, "R9 overlap", W'(m_valid), W'(0));
    send(oq);
    for (int z = sp; z >= st; z--) send(od[z] ^ nw[z]);
    for (int i = 0; i < st; i++) begin
      chk(!m_valid && !s_ready, "R6 doubling gap", W'({m_valid, s_ready}), W'(0));
      @(negedge clk);
    end
    chk(m_valid, "R6 result timing", W'(m_valid), W'(1));
    chk(m_p == dsum, "R3 P update", m_p, dsum);
    chk(m_p == ep, "R10 P regen", m_p, ep);
    chk(m_q == eq, (pattern == 1) ? "R5 Q byte doubling" : "R4 Q update", m_q, eq);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(m_valid && m_p == ep && m_q == eq, "R7 hold", m_q, eq);
    end
    if (!leave) begin
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
      chk(!m_valid, "R7 drain", W'(m_valid), W'(0));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_data = '0;
    cfg_ndev = '0; cfg_start = '0; cfg_stop = '0;
    repeat (3) @(negedge clk);
    chk(!m_valid && !err_o && s_ready, "R1 in reset", W'({m_valid, err_o, s_ready}), W'(1));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!m_valid && !err_o && s_ready, "R1 after reset", W'({m_valid, err_o, s_ready}), W'(1));
  endtask

  task automatic t_err(input int nd, input int st, input int sp);
    cfg_ndev = IDX_W'(nd); cfg_start = IDX_W'(st); cfg_stop = IDX_W'(sp);
    send(rnd_v());
    chk(err_o && !m_valid, "R8 reject pulse", W'({err_o, m_valid}), W'(2));
    @(negedge clk);
    chk(!err_o && !m_valid && s_ready, "R8 back to idle", W'({err_o, m_valid, s_ready}), W'(1));
  endtask

  task automatic t_b2b();
    do_job(9, 1, 4, 1, 1'b0, 1'b1, 0);
    do_job(11, 2, 6, 0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_random();
    for (int r = 0; r < 6; r++) begin
      int nd, st, sp;
      nd = 3 + int'($urandom_range(0, 14));
      sp = int'($urandom_range(0, nd-3));
      st = int'($urandom_range(0, sp));
      do_job(nd, st, sp, r % 2, 1'b0, 1'b0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    do_job(8, 0, 5, 0, 1'b0, 1'b0, 0);   // R2 full data range
    do_job(10, 3, 5, 3, 1'b0, 1'b0, 0);  // R7 hold with middle range
    do_job(6, 2, 2, 0, 1'b0, 1'b0, 0);   // single device
    do_job(12, 9, 9, 0, 1'b0, 1'b0, 0);  // long doubling tail
    do_job(3, 0, 0, 0, 1'b0, 1'b0, 0);   // smallest stripe
    do_job(7, 1, 3, 0, 1'b0, 1'b0, 1);   // R5 top-bit bytes
    t_err(8, 4, 3);                      // R8 start above stop
    t_err(8, 2, 6);                      // R8 stop beyond data devices
    t_err(2, 0, 0);                      // R8 too few devices
    t_b2b();                             // R9
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule